// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of activation vectors by a fixed weight matrix on a grid of `ROWS` x `COLS` multiply-accumulate cells. The grid first receives its weights. A strobe shifts one column of weights into the left edge of the grid per cycle, and the previously loaded columns move one step to the right. Each cell keeps its weight for as long as the matrix is in use. No weight is fetched a second time.

During streaming, element k of each activation vector enters grid row k, delayed by k cycles with respect to element 0. The caller applies this delay. Activations travel rightwards one cell per cycle. Partial sums travel downwards one cell per cycle, starting from zero at the top row. The finished dot product for column n leaves the bottom of that column. Inside the block, each bottom output is delayed so that all columns of a result vector appear in the same cycle, together with a valid flag. A flag presented with element 0 of a vector returns with its result `ROWS+COLS-1` cycles later. Operands are signed 8-bit values. Sums are signed 32-bit values.

Top module: `wsSystolicMm`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `weightsReady` and `resValid` are 0.
- R2: `weightsReady` becomes 1 in the cycle after the `COLS`-th `wLoad` strobe counted since reset. A `wLoad` strobe while `weightsReady` is 1 restarts the count at one, so `weightsReady` drops to 0. It returns to 1 after the strobes that complete the new set. Without `wLoad`, `weightsReady` holds its value.
- R3: Each strobe shifts weights one column to the right. The weight for grid row k is taken from `wIn[k*8 +: 8]`. The column loaded first therefore ends in column `COLS-1`, and the column loaded last ends in column 0.
- R4: A result vector carries, in `resVec[n*32 +: 32]`, the signed sum over k of A[m][k]*W[k][n], where W[k][n] is the weight held at row k, column n.
- R5: Element k of vector m must be applied on `actIn[k*8 +: 8]` exactly k cycles after element 0 of that vector. Vectors may follow one another in consecutive cycles, and each one then yields its own result in consecutive cycles.
- R6: `actValid` high in the cycle that element 0 of vector m is applied produces `resValid` high exactly `ROWS+COLS-1` cycles later. All columns of that result are present in that same cycle.
- R7: The extreme products do not overflow. With every operand equal to -128, each column result equals `ROWS`*16384. Mixed 127 and -128 operands sum exactly.
- R8: `actValid` has no effect while `weightsReady` is 0 or `wLoad` is 1. No `resValid` follows from it, and activations arriving in such a cycle enter the grid as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wLoad | input | 1 | Shift one weight column into the grid |
| wIn | input | ROWS*8 | Weight column, row k in bits k*8 upward |
| actValid | input | 1 | Marks element 0 of an activation vector |
| actIn | input | ROWS*8 | Skewed activations, row k in bits k*8 upward |
| weightsReady | output | 1 | A full weight set is loaded |
| resValid | output | 1 | `resVec` holds a finished result vector |
| resVec | output | COLS*32 | Result vector, column n in bits n*32 upward |

## Verification
The bench builds the grid with four rows and three columns. With a non-square shape, exchanging row and column indices, or reversing the column load order, changes the results it checks. The shape also gives a fill latency of six cycles, which differs from either dimension alone, so an off-by-one in the skew, the de-skew or the valid pipe shifts the captured cycle. Back-to-back vectors with distinct values show whether results from neighbouring vectors bleed into each other. Reloading with all-extreme weights reaches the largest product magnitudes.

// File: rtl/mmPkg.sv
package mmPkg;
  // Strobes from control into the datapath
  typedef struct packed {
    logic shiftW;    // shift a weight column in
    logic streamEn;  // activations may enter the grid
  } mmStrobe_t;
endpackage

// File: rtl/mmPe.sv
module mmPe #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] act,
  input  logic [DATA_W-1:0] weight,
  input  logic [ACC_W-1:0]  psumIn,
  output logic [ACC_W-1:0]  psumOut
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0] prodExt;

  always_comb begin
    prod    = $signed(act) * $signed(weight);
    prodExt = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  always_ff @(posedge clk) begin
    if (!rstN) psumOut <= '0;
    else       psumOut <= psumIn + prodExt;
  end
endmodule

// File: rtl/mmControl.sv
module mmControl
  import mmPkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wLoad,
  input  logic      actValid,
  output mmStrobe_t strb,
  output logic      weightsReady,
  output logic      resValid
);
  localparam int LAT   = ROWS + COLS - 1;
  localparam int CNT_W = $clog2(COLS + 1);

  logic [CNT_W-1:0] loadCnt;
  logic [LAT-1:0]   validPipe;
  logic             feedValid;

  assign weightsReady = (loadCnt == CNT_W'(COLS));

  always_comb begin
    strb.shiftW   = wLoad;
    strb.streamEn = weightsReady && !wLoad;
    feedValid     = actValid && strb.streamEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadCnt <= '0;
    end else if (wLoad) begin
      loadCnt <= weightsReady ? CNT_W'(1) : loadCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= LAT'({validPipe, feedValid});
  end

  assign resValid = validPipe[LAT-1];
endmodule

// File: rtl/mmDatapath.sv
module mmDatapath
  import mmPkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  mmStrobe_t              strb,
  input  logic [ROWS*DATA_W-1:0] wIn,
  input  logic [ROWS*DATA_W-1:0] actIn,
  output logic [COLS*ACC_W-1:0]  resVec
);
  logic [DATA_W-1:0] wReg   [ROWS][COLS];
  logic [DATA_W-1:0] actSrc [ROWS][COLS];
  logic [ACC_W-1:0]  psum   [ROWS+1][COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_top
    assign psum[0][c] = '0;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign actSrc[r][0] = strb.streamEn ? actIn[r*DATA_W +: DATA_W] : '0;

    for (genvar c = 0; c < COLS; c++) begin : g_col
      // weight shift chain along the row
      always_ff @(posedge clk) begin
        if (!rstN) wReg[r][c] <= '0;
        else if (strb.shiftW)
          wReg[r][c] <= (c == 0) ? wIn[r*DATA_W +: DATA_W] : wReg[r][(c == 0) ? 0 : c-1];
      end

      // activation forwarding register to the right neighbour
      if (c < COLS - 1) begin : g_fwd
        always_ff @(posedge clk) begin
          if (!rstN) actSrc[r][c+1] <= '0;
          else       actSrc[r][c+1] <= actSrc[r][c];
        end
      end

      mmPe #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_pe (
        .clk    (clk),
        .rstN   (rstN),
        .act    (actSrc[r][c]),
        .weight (wReg[r][c]),
        .psumIn (psum[r][c]),
        .psumOut(psum[r+1][c])
      );
    end
  end

  // de-skew: column c waits COLS-1-c cycles
  for (genvar c = 0; c < COLS; c++) begin : g_deskew
    localparam int D = COLS - 1 - c;
    if (D == 0) begin : g_pass
      assign resVec[c*ACC_W +: ACC_W] = psum[ROWS][c];
    end else begin : g_dly
      logic [ACC_W-1:0] sh [D];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < D; i++) sh[i] <= '0;
        end else begin
          sh[0] <= psum[ROWS][c];
          for (int i = 1; i < D; i++) sh[i] <= sh[i-1];
        end
      end
      assign resVec[c*ACC_W +: ACC_W] = sh[D-1];
    end
  end
endmodule

// File: rtl/wsSystolicMm.sv
module wsSystolicMm
  import mmPkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wLoad,
  input  logic [ROWS*DATA_W-1:0] wIn,
  input  logic                   actValid,
  input  logic [ROWS*DATA_W-1:0] actIn,
  output logic                   weightsReady,
  output logic                   resValid,
  output logic [COLS*ACC_W-1:0]  resVec
);
  mmStrobe_t strb;

  mmControl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wLoad       (wLoad),
    .actValid    (actValid),
    .strb        (strb),
    .weightsReady(weightsReady),
    .resValid    (resValid)
  );

  mmDatapath #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wIn   (wIn),
    .actIn (actIn),
    .resVec(resVec)
  );
endmodule

// File: rtl/mmSysChecker.sv
module mmSysChecker #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wLoad,
  input logic                   actValid,
  input logic                   weightsReady,
  input logic                   resValid,
  input logic [COLS*ACC_W-1:0]  resVec
);
  logic fedOnce;

  always_ff @(posedge clk) begin
    if (!rstN) fedOnce <= 1'b0;
    else if (actValid && weightsReady && !wLoad) fedOnce <= 1'b1;
  end

  AST_READY_BY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weightsReady) |-> $past(wLoad)); // R2

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wLoad |=> $stable(weightsReady)); // R2

  AST_RELOAD_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (wLoad && weightsReady && (COLS > 1)) |=> !weightsReady); // R2

  AST_NO_UNFED_VALID: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> fedOnce); // R8

  AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !$isunknown(resVec)); // R4
endmodule

bind wsSystolicMm mmSysChecker #(
  .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .ACC_W(ACC_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wLoad       (wLoad),
  .actValid    (actValid),
  .weightsReady(weightsReady),
  .resValid    (resValid),
  .resVec      (resVec)
);

// File: tb/wsSystolicMm_tb.sv
module wsSystolicMm_tb;
  localparam int ROWS = 4;
  localparam int COLS = 3;
  localparam int LAT  = ROWS + COLS - 1;
  localparam int MAXV = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wLoad = 1'b0;
  logic [ROWS*8-1:0] wIn = '0;
  logic actValid = 1'b0;
  logic [ROWS*8-1:0] actIn = '0;
  logic weightsReady, resValid;
  logic [COLS*32-1:0] resVec;

  always #2 clk = ~clk;  // 250 MHz

  wsSystolicMm #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rstN(rstN), .wLoad(wLoad), .wIn(wIn),
    .actValid(actValid), .actIn(actIn),
    .weightsReady(weightsReady), .resValid(resValid), .resVec(resVec)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  int bMat [ROWS][COLS];
  int aMat [MAXV][ROWS];

  logic [COLS*32-1:0] capVec [16];
  int capCyc [16];
  int nCap = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (resValid && nCap < 16) begin
      capVec[nCap] = resVec;
      capCyc[nCap] = cyc;
      nCap = nCap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expC(int m, int n);
    int s = 0;
    for (int k = 0; k < ROWS; k++) s += aMat[m][k] * bMat[k][n];
    return s;
  endfunction

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(weightsReady == 1'b0, "R1", "ready in reset", weightsReady, 0);
    chk(resValid == 1'b0, "R1", "valid in reset", resValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(weightsReady == 1'b0, "R1", "ready after reset", weightsReady, 0);
    chk(resValid == 1'b0, "R1", "valid after reset", resValid, 0);
  endtask

  // strobe j carries column COLS-1-j (R3)
  task automatic tLoad();
    for (int j = 0; j < COLS; j++) begin
      @(negedge clk);
      if (j == 1)
        chk(weightsReady == 1'b0, "R2", "ready mid load", weightsReady, 0);
      wLoad = 1'b1;
      for (int k = 0; k < ROWS; k++) wIn[k*8 +: 8] = 8'(bMat[k][COLS-1-j]);
    end
    @(negedge clk);
    wLoad = 1'b0;
    wIn = '0;
    chk(weightsReady == 1'b1, "R2", "ready after full load", weightsReady, 1);
    @(negedge clk);
    chk(weightsReady == 1'b1, "R2", "ready holds", weightsReady, 1);
  endtask

  // feed numV vectors back to back with row skew (R5)
  task automatic tStream(input int numV, output int c0);
    nCap = 0;
    for (int s = 0; s < numV + ROWS - 1; s++) begin
      @(negedge clk);
      if (s == 0) c0 = cyc;
      actValid = (s < numV);
      for (int k = 0; k < ROWS; k++) begin
        int m = s - k;
        actIn[k*8 +: 8] = (m >= 0 && m < numV) ? 8'(aMat[m][k]) : 8'd0;
      end
    end
    @(negedge clk);
    actValid = 1'b0;
    actIn = '0;
    repeat (LAT + 3) @(negedge clk);
  endtask

  task automatic tCheckResults(input int numV, input int c0, input string req);
    chk(nCap == numV, req, "result count", nCap, numV);
    for (int m = 0; m < numV && m < nCap; m++) begin
      chk(capCyc[m] == c0 + m + LAT, "R6", "result cycle", capCyc[m], c0 + m + LAT);
      for (int n = 0; n < COLS; n++)
        chk($signed(capVec[m][n*32 +: 32]) == expC(m, n), req, "column sum",
            $signed(capVec[m][n*32 +: 32]), expC(m, n));
    end
  endtask

  task automatic tUnready();
    int c0;
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < ROWS; k++) aMat[m][k] = k + 1;
    tStream(2, c0);
    chk(nCap == 0, "R8", "valids without weights", nCap, 0);
  endtask

  task automatic tSingle();
    int c0;
    for (int k = 0; k < ROWS; k++)
      for (int n = 0; n < COLS; n++) bMat[k][n] = (k + 1) * 10 + n - 7;
    tLoad();
    for (int k = 0; k < ROWS; k++) aMat[0][k] = 3 - 2 * k;
    tStream(1, c0);
    tCheckResults(1, c0, "R3");
  endtask

  task automatic tBurst();
    int c0;
    for (int m = 0; m < 5; m++)
      for (int k = 0; k < ROWS; k++) aMat[m][k] = ((m * 37 + k * 53) % 251) - 125;
    tStream(5, c0);
    tCheckResults(5, c0, "R5");
  endtask

  task automatic tExtreme();
    int c0;
    for (int k = 0; k < ROWS; k++)
      for (int n = 0; n < COLS; n++) bMat[k][n] = (n == 1 && k[0]) ? 127 : -128;
    tLoad();  // reload from full: R2 drop checked inside
    for (int k = 0; k < ROWS; k++) begin
      aMat[0][k] = -128;
      aMat[1][k] = k[0] ? 127 : -128;
    end
    tStream(2, c0);
    tCheckResults(2, c0, "R7");
    if (nCap > 0)
      chk($signed(capVec[0][31:0]) == ROWS * 16384, "R7", "all -128 column",
          $signed(capVec[0][31:0]), ROWS * 16384);
  endtask

  task automatic tGateDuringLoad();
    int c0;
    @(negedge clk);
    wLoad = 1'b1;
    actValid = 1'b1;
    c0 = cyc;
    @(negedge clk);
    wLoad = 1'b0;
    actValid = 1'b0;
    nCap = 0;
    repeat (LAT + 3) @(negedge clk);
    chk(nCap == 0, "R8", "valid during reload strobe", nCap, 0);
    chk(weightsReady == 1'b0, "R2", "partial reload not ready", weightsReady, 0);
  endtask

  initial begin
    tReset();
    tUnready();
    tSingle();
    tBurst();
    tExtreme();
    tGateDuringLoad();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule